// File: doc/BRIEF.md
# Synchronous Burst ROM Read Interface

This block is the device-side logic of a synchronous read-only memory. Everything is sampled on the rising clock edge. Row and column addresses share one address bus. Three strobes and a chip select carry the commands: a row strobe opens a row, a column strobe starts a burst read, and a mode strobe loads the timing settings from the address bus. Each burst returns eight words in a fixed order. The row-to-column spacing, the column-to-data latency and the beat ordering are all programmable.

A width input selects the organization of the array. It can read out 32-bit words with an 8-bit column, or 16-bit words with a 9-bit column. The storage is a computed table, so no initialisation file is needed. A clock-enable input freezes the block one cycle after it is sampled low. A data-mask input suppresses single output beats. Instead of a tri-state pin, the output reports high impedance as `dq_oe` low with `dq` at zero.

Top module: `sync_burst_rom`

## Requirements
- R1: Commands are decoded on the rising edge. Each needs `cs_n` low. Mode load: `mr_n` low, with the strobes ignored. Row: `ras_n` low, `cas_n` high, `mr_n` high. Column: `cas_n` low, `ras_n` high, `mr_n` high. Any other pattern is a no-op.
- R2: After reset, `dq_oe`, `dq` and `err_pulse` are 0. The mode is row latency 1, column latency 3 and sequential ordering.
- R3: The mode key on `addr` is decoded as follows. Bit 0 sets the row latency (0 gives 1 cycle, 1 gives 2). Bits 3..1 hold the column latency minus 2. Bit 4 sets the ordering (0 sequential, 1 interleaved).
- R4: A mode load whose bits 3..1 equal 7 is discarded completely.
- R5: A column command is accepted only at an edge at least the row latency after the last row command. A column command that comes earlier, or before any row command, is dropped. In that case `err_pulse` is high for the single cycle after it.
- R6: The first word of a burst is registered at the edge that lies the column latency after the accepted column edge. Until then `dq_oe` is 0 and `dq` is 0.
- R7: A burst delivers 8 words on consecutive cycles. In the cycle after the last word, `dq_oe` returns to 0.
- R8: Beat i uses the start column with its low three bits replaced. Sequential ordering uses (start+i) mod 8. Interleaved ordering uses start XOR i.
- R9: Define D(a) = (a * 0x9E3779B1) XOR 0x5A5A5A5A, taken to 32 bits. With `half_width`=0, the column is `addr[7:0]` and the word is D({row,col}). With `half_width`=1, the column is `addr[8:0]`. Let w = {row,col}. The output is the low half of D(w>>1) when w[0]=0 and the high half when w[0]=1, with the upper 16 bits of `dq` zero. `half_width` is taken at the column command.
- R10: `dqm` high at the edge that registers a beat leaves that beat masked (`dq_oe`=0). The beats that follow are unaffected.
- R11: `cke` sampled low at one edge freezes all state, including the outputs, at the next edge.
- R12: With `cs_n` high, the mode, row and column commands have no effect.
- R13: An accepted column command during a burst ends that burst. `dq_oe` is 0 in the next cycle, and the new burst waits its full column latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable, freezes one cycle later |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| mr_n | input | 1 | Mode-load strobe, active low |
| half_width | input | 1 | 1 selects 16-bit words |
| dqm | input | 1 | Output mask for the beat being registered |
| addr | input | 13 | Multiplexed row/column/mode-key bus |
| dq | output | 32 | Read data, zero when not driven |
| dq_oe | output | 1 | Output drive enable; 0 means high impedance |
| err_pulse | output | 1 | One-cycle flag for a too-early column command |

## Verification
The first burst uses the reset mode and a mid-row start column, which checks the default latency and sequential wrap. Later bursts use interleaved ordering with the shortest latency, and the longest latency in 16-bit mode with a start column near the end of a row. Together these separate the two orderings, the halves of a double word and every edge of the latency count. A rejected mode key and strobes issued with chip select high are followed by a normal burst, so any setting that changed by mistake shows up in its timing or order. Masking, freezing and restarting are each applied in the middle of a burst, so the beats before and after them show exactly which beat was affected.

// File: rtl/sbr_pkg.sv
// Shared types for the synchronous burst ROM.
// Assumes a fixed 5-bit mode key layout on the low address bits.
package sbr_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_RUN  = 2'd2
    } phase_e;

    typedef struct packed {
        logic       ilv;      // 1: interleaved beat order
        logic [2:0] cl_code;  // column latency minus two
        logic       rl2;      // 1: two-cycle row latency
    } mode_t;

    localparam int KEY_W = 5;
    localparam logic [2:0] CL_ILLEGAL = 3'b111;
    localparam mode_t MODE_RESET = '{ilv: 1'b0, cl_code: 3'd1, rl2: 1'b0};

endpackage

// File: rtl/sbr_mode_reg.sv
// Mode register: holds row latency, column latency and beat order.
// Assumes the load strobe is already qualified by chip select.
// A key carrying the reserved latency code is dropped entirely.
module sbr_mode_reg
    import sbr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             load,
    input  logic [KEY_W-1:0] key,
    output mode_t            mode
);

    // Capture a legal key on an enabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= MODE_RESET;
        end else if (en && load && (key[3:1] != CL_ILLEGAL)) begin
            mode.rl2     <= key[0];
            mode.cl_code <= key[3:1];
            mode.ilv     <= key[4];
        end
    end

endmodule

// File: rtl/sbr_row_timer.sv
// Row tracker: latches the row address and counts the cycles since the
// last row command, judging whether a column command may be accepted.
// Assumes row and column commands are mutually exclusive.
module sbr_row_timer #(
    parameter int ROW_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             row_cmd,
    input  logic             col_cmd,
    input  logic             rl2,
    input  logic [ROW_W-1:0] row_in,
    output logic [ROW_W-1:0] row_q,
    output logic             col_ok,
    output logic             err_pulse
);

    localparam logic [1:0] AGE_MAX = 2'd2;

    logic       row_open;
    logic [1:0] age;

    // Open a row and age it until the longest latency is covered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_open <= 1'b0;
            age      <= '0;
            row_q    <= '0;
        end else if (en) begin
            if (row_cmd) begin
                row_open <= 1'b1;
                age      <= 2'd1;
                row_q    <= row_in;
            end else if (row_open && (age < AGE_MAX)) begin
                age <= age + 2'd1;
            end
        end
    end

    // A column command is legal once the programmed spacing has elapsed.
    always_comb begin
        col_ok = row_open && (age >= (rl2 ? 2'd2 : 2'd1));
    end

    // Flag a rejected column command for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_pulse <= 1'b0;
        end else if (en) begin
            err_pulse <= col_cmd && !col_ok;
        end
    end

endmodule

// File: rtl/sbr_rom_array.sv
// Computed read-only array: a double-word table formed by hashing the
// address, with half-word selection in 16-bit organization.
// Assumes the column MSB is zero in 32-bit organization.
module sbr_rom_array #(
    parameter int ROW_W  = 13,
    parameter int COL_W  = 9,
    parameter int DATA_W = 32
) (
    input  logic [ROW_W-1:0]  row,
    input  logic [COL_W-1:0]  col,
    input  logic              half,
    output logic [DATA_W-1:0] data
);

    localparam int AW     = ROW_W + COL_W - 1;
    localparam int HALF_W = DATA_W / 2;
    localparam logic [DATA_W-1:0] HASH_MUL = DATA_W'(32'h9E3779B1);
    localparam logic [DATA_W-1:0] HASH_XOR = DATA_W'(32'h5A5A5A5A);

    logic [AW-1:0]     dw_addr;
    logic [DATA_W-1:0] raw;

    // Form the double-word address and its stored value.
    always_comb begin
        dw_addr = half ? {row, col[COL_W-1:1]} : {row, col[COL_W-2:0]};
        raw     = (DATA_W'(dw_addr) * HASH_MUL) ^ HASH_XOR;
    end

    // Pick the full word or the addressed half.
    always_comb begin
        if (!half) begin
            data = raw;
        end else if (col[0]) begin
            data = {{HALF_W{1'b0}}, raw[DATA_W-1:HALF_W]};
        end else begin
            data = {{HALF_W{1'b0}}, raw[HALF_W-1:0]};
        end
    end

endmodule

// File: rtl/sbr_burst_ctrl.sv
// Burst sequencer: waits out the column latency, then registers one word
// per cycle in sequential or interleaved order and applies the beat mask.
// Assumes a power-of-two burst length not larger than the column span.
module sbr_burst_ctrl
    import sbr_pkg::*;
#(
    parameter int ROW_W     = 13,
    parameter int COL_W     = 9,
    parameter int DATA_W    = 32,
    parameter int BURST_LEN = 8,
    parameter int CLW       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              start,
    input  logic [ROW_W-1:0]  row_in,
    input  logic [COL_W-1:0]  col_in,
    input  logic              half_in,
    input  logic [CLW-1:0]    cl,
    input  logic              ilv,
    input  logic              dqm,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ROW_W-1:0]  rd_row,
    output logic [COL_W-1:0]  rd_col,
    output logic              rd_half,
    output logic [DATA_W-1:0] dout,
    output logic              oe
);

    localparam int BW = $clog2(BURST_LEN);
    localparam logic [BW-1:0] LAST = BW'(BURST_LEN - 1);

    phase_e          phase;
    logic [CLW-1:0]  lat;
    logic [BW-1:0]   beat;
    logic [COL_W-1:0] col_l;
    logic            ilv_l;
    logic [BW-1:0]   low_bits;

    // Order the low column bits for the current beat.
    always_comb begin
        low_bits = ilv_l ? (col_l[BW-1:0] ^ beat) : (col_l[BW-1:0] + beat);
        rd_col   = {col_l[COL_W-1:BW], low_bits};
    end

    // Advance the latency wait and the beat sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            lat     <= '0;
            beat    <= '0;
            rd_row  <= '0;
            col_l   <= '0;
            rd_half <= 1'b0;
            ilv_l   <= 1'b0;
            dout    <= '0;
            oe      <= 1'b0;
        end else if (en) begin
            if (start) begin
                phase   <= PH_WAIT;
                lat     <= cl - CLW'(1);
                beat    <= '0;
                rd_row  <= row_in;
                col_l   <= col_in;
                rd_half <= half_in;
                ilv_l   <= ilv;
                oe      <= 1'b0;
            end else begin
                case (phase)
                    PH_WAIT: begin
                        if (lat == '0) begin
                            dout  <= rd_data;
                            oe    <= !dqm;
                            beat  <= beat + BW'(1);
                            phase <= PH_RUN;
                        end else begin
                            lat <= lat - CLW'(1);
                        end
                    end
                    PH_RUN: begin
                        dout <= rd_data;
                        oe   <= !dqm;
                        if (beat == LAST) begin
                            phase <= PH_IDLE;
                        end else begin
                            beat <= beat + BW'(1);
                        end
                    end
                    default: begin
                        oe <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/sync_burst_rom.sv
// Top of the synchronous burst ROM: registers clock enable, decodes the
// strobes under chip select and ties mode, row timing, array and burst
// sequencing together. Assumes COL_W is no wider than ROW_W.
module sync_burst_rom
    import sbr_pkg::*;
#(
    parameter int ROW_W     = 13,
    parameter int COL_W     = 9,
    parameter int DATA_W    = 32,
    parameter int BURST_LEN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              mr_n,
    input  logic              half_width,
    input  logic              dqm,
    input  logic [ROW_W-1:0]  addr,
    output logic [DATA_W-1:0] dq,
    output logic              dq_oe,
    output logic              err_pulse
);

    localparam int CLW = 4;

    logic              cke_q;
    logic              active;
    logic              mr_cmd;
    logic              row_cmd;
    logic              col_cmd;
    logic              col_ok;
    logic              start;
    logic [COL_W-1:0]  col_in;
    logic [CLW-1:0]    cl_cycles;
    mode_t             mode_q;
    logic [ROW_W-1:0]  row_q;
    logic [ROW_W-1:0]  rd_row;
    logic [COL_W-1:0]  rd_col;
    logic              rd_half;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] dout;

    // Delay clock enable so a low sample freezes the following edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cke_q <= 1'b1;
        end else begin
            cke_q <= cke;
        end
    end

    // Decode commands and shape the column address.
    always_comb begin
        active    = cke_q;
        mr_cmd    = !cs_n && !mr_n;
        row_cmd   = !cs_n && mr_n && !ras_n && cas_n;
        col_cmd   = !cs_n && mr_n && ras_n && !cas_n;
        start     = col_cmd && col_ok;
        col_in    = half_width ? addr[COL_W-1:0] : {1'b0, addr[COL_W-2:0]};
        cl_cycles = CLW'(mode_q.cl_code) + CLW'(2);
    end

    sbr_mode_reg u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (active),
        .load  (mr_cmd),
        .key   (addr[KEY_W-1:0]),
        .mode  (mode_q)
    );

    sbr_row_timer #(.ROW_W(ROW_W)) u_row (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (active),
        .row_cmd   (row_cmd),
        .col_cmd   (col_cmd),
        .rl2       (mode_q.rl2),
        .row_in    (addr),
        .row_q     (row_q),
        .col_ok    (col_ok),
        .err_pulse (err_pulse)
    );

    sbr_rom_array #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_array (
        .row  (rd_row),
        .col  (rd_col),
        .half (rd_half),
        .data (rd_data)
    );

    sbr_burst_ctrl #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
        .BURST_LEN(BURST_LEN), .CLW(CLW)
    ) u_burst (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (active),
        .start   (start),
        .row_in  (row_q),
        .col_in  (col_in),
        .half_in (half_width),
        .cl      (cl_cycles),
        .ilv     (mode_q.ilv),
        .dqm     (dqm),
        .rd_data (rd_data),
        .rd_row  (rd_row),
        .rd_col  (rd_col),
        .rd_half (rd_half),
        .dout    (dout),
        .oe      (dq_oe)
    );

    // Drive zero whenever the output is released.
    always_comb begin
        dq = dq_oe ? dout : '0;
    end

endmodule

// File: rtl/sbr_checks.sv
// Protocol checker for the synchronous burst ROM, attached by bind.
// Assumes it sees the decoded commands and the row timer's verdict.
module sbr_checks #(
    parameter int ROW_W  = 13,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              active,
    input logic              cs_n,
    input logic              col_cmd,
    input logic              mr_cmd,
    input logic              col_ok,
    input logic [ROW_W-1:0]  addr,
    input logic [3:0]        cl_cycles,
    input logic [DATA_W-1:0] dq,
    input logic              dq_oe,
    input logic              err_pulse
);

    // R13
    restart_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && col_cmd && col_ok) |=> !dq_oe);

    // R5
    early_column_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && col_cmd && !col_ok) |=> err_pulse);

    // R11
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> ($stable(dq) && $stable(dq_oe)));

    // R4
    illegal_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && mr_cmd && (addr[3:1] == 3'b111)) |=> $stable(cl_cycles));

    // R12
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cs_n) |=> !err_pulse);

endmodule

bind sync_burst_rom sbr_checks #(.ROW_W(ROW_W), .DATA_W(DATA_W)) u_sbr_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .cs_n      (cs_n),
    .col_cmd   (col_cmd),
    .mr_cmd    (mr_cmd),
    .col_ok    (col_ok),
    .addr      (addr),
    .cl_cycles (cl_cycles),
    .dq        (dq),
    .dq_oe     (dq_oe),
    .err_pulse (err_pulse)
);

// File: tb/sync_burst_rom_bench.sv
module sync_burst_rom_bench;

    logic        clk = 1'b0;
    logic        rst_n, cke, cs_n, ras_n, cas_n, mr_n, half_width, dqm;
    logic [12:0] addr;
    logic [31:0] dq;
    logic        dq_oe, err_pulse;
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    sync_burst_rom u_sync_burst_rom (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .mr_n(mr_n), .half_width(half_width), .dqm(dqm),
        .addr(addr), .dq(dq), .dq_oe(dq_oe), .err_pulse(err_pulse)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        cs_n = 1; ras_n = 1; cas_n = 1; mr_n = 1; addr = '0;
    endtask

    task automatic nop();
        @(negedge clk);
    endtask

    task automatic put(input logic cs, input logic ras, input logic cas, input logic mr, input logic [12:0] a);
        cs_n = cs; ras_n = ras; cas_n = cas; mr_n = mr; addr = a;
        @(negedge clk);
        idle();
    endtask

    task automatic load_mode(input int rl, input int cl, input bit ilv);
        put(0, 1, 1, 0, {8'b0, ilv, 3'(cl - 2), 1'(rl - 1)});
    endtask

    function automatic logic [31:0] dword(input logic [21:0] a);
        return (32'(a) * 32'h9E3779B1) ^ 32'h5A5A5A5A;
    endfunction

    function automatic logic [31:0] expw(input logic [12:0] row, input logic [8:0] col, input bit half);
        logic [21:0] w;
        logic [31:0] d;
        if (!half) return dword({1'b0, row, col[7:0]});
        w = {row, col};
        d = dword(w >> 1);
        return w[0] ? {16'h0, d[31:16]} : {16'h0, d[15:0]};
    endfunction

    function automatic logic [8:0] bcol(input logic [8:0] col, input int i, input bit ilv);
        logic [2:0] lo;
        lo = ilv ? (col[2:0] ^ 3'(i)) : (col[2:0] + 3'(i));
        return {col[8:3], lo};
    endfunction

    task automatic expect_off(input string req);
        chk(dq_oe === 1'b0 && dq === 32'h0, req, dq | 32'(dq_oe), 32'h0);
    endtask

    task automatic expect_word(input logic [12:0] row, input logic [8:0] col, input bit half, input string req);
        logic [31:0] e;
        e = expw(row, col, half);
        chk(dq_oe === 1'b1 && dq === e, req, dq, e);
    endtask

    task automatic open_row(input logic [12:0] row, input int rl);
        put(0, 0, 1, 1, row);
        repeat (rl - 1) nop();
    endtask

    task automatic read_col(input logic [8:0] col, input bit half);
        half_width = half;
        put(0, 1, 0, 1, {4'b0, col});
    endtask

    // Called right after the column command edge.
    task automatic check_burst(input logic [12:0] row, input logic [8:0] col, input bit half,
                               input int cl, input bit ilv, input string req);
        logic [8:0] c;
        c = half ? col : {1'b0, col[7:0]};
        repeat (cl - 1) nop();
        expect_off(req);
        for (int i = 0; i < 8; i++) begin
            nop();
            expect_word(row, bcol(c, i, ilv), half, req);
        end
        nop();
        expect_off(req);
    endtask

    task automatic t_reset();
        rst_n = 0; cke = 1; dqm = 0; half_width = 0; idle();
        repeat (3) nop();
        expect_off("R2 reset output");
        chk(err_pulse === 1'b0, "R2 reset flag", 32'(err_pulse), 0);
        rst_n = 1;
        nop();
    endtask

    task automatic t_default();
        open_row(13'h1ABC, 1);
        read_col(9'h035, 0);
        check_burst(13'h1ABC, 9'h035, 0, 3, 0, "R2 R1 R6 R7 R8 R9 default read");
    endtask

    task automatic t_interleave();
        load_mode(2, 2, 1);
        open_row(13'h0123, 2);
        read_col(9'h05E, 0);
        check_burst(13'h0123, 9'h05E, 0, 2, 1, "R3 R8 interleaved cl2");
    endtask

    task automatic t_early();
        put(0, 0, 1, 1, 13'h0777);
        read_col(9'h010, 0);
        chk(err_pulse === 1'b1, "R5 early flag", 32'(err_pulse), 1);
        nop();
        chk(err_pulse === 1'b0, "R5 flag one cycle", 32'(err_pulse), 0);
        for (int i = 0; i < 10; i++) begin
            nop();
            expect_off("R5 early ignored");
        end
    endtask

    task automatic t_illegal();
        put(0, 1, 1, 0, {8'b0, 1'b0, 3'b111, 1'b0});
        open_row(13'h0042, 2);
        read_col(9'h0F9, 0);
        check_burst(13'h0042, 9'h0F9, 0, 2, 1, "R4 illegal key ignored");
    endtask

    task automatic t_half_long();
        load_mode(1, 8, 0);
        open_row(13'h1F00, 1);
        read_col(9'h1FD, 1);
        check_burst(13'h1F00, 9'h1FD, 1, 8, 0, "R6 R8 R9 half width cl8 wrap");
        half_width = 0;
    endtask

    task automatic t_mask();
        load_mode(1, 4, 0);
        open_row(13'h0A0A, 1);
        read_col(9'h020, 0);
        repeat (3) nop();
        expect_off("R10 latency");
        nop(); expect_word(13'h0A0A, 9'h020, 0, "R10 beat0");
        nop(); expect_word(13'h0A0A, 9'h021, 0, "R10 beat1");
        dqm = 1;
        nop(); expect_off("R10 masked beat2");
        dqm = 0;
        nop(); expect_word(13'h0A0A, 9'h023, 0, "R10 beat3 after mask");
        repeat (6) nop();
        expect_off("R7 R10 end");
    endtask

    task automatic t_freeze();
        open_row(13'h0BEE, 1);
        read_col(9'h044, 0);
        repeat (3) nop();
        nop(); expect_word(13'h0BEE, 9'h044, 0, "R11 beat0");
        nop(); expect_word(13'h0BEE, 9'h045, 0, "R11 beat1");
        cke = 0;
        nop(); expect_word(13'h0BEE, 9'h046, 0, "R11 beat2");
        cke = 1;
        nop(); expect_word(13'h0BEE, 9'h046, 0, "R11 beat2 held");
        nop(); expect_word(13'h0BEE, 9'h047, 0, "R11 beat3 resumes");
        repeat (6) nop();
    endtask

    task automatic t_deselect();
        put(1, 1, 1, 0, {8'b0, 1'b1, 3'd0, 1'b1});
        put(1, 0, 1, 1, 13'h1111);
        put(1, 1, 0, 1, 13'h0033);
        chk(err_pulse === 1'b0, "R12 no flag", 32'(err_pulse), 0);
        for (int i = 0; i < 14; i++) begin
            nop();
            expect_off("R12 no burst");
        end
        read_col(9'h0C3, 0);
        check_burst(13'h0BEE, 9'h0C3, 0, 4, 0, "R12 mode and row kept");
    endtask

    task automatic t_restart();
        open_row(13'h0505, 1);
        read_col(9'h070, 0);
        repeat (3) nop();
        nop(); expect_word(13'h0505, 9'h070, 0, "R13 old beat0");
        nop(); expect_word(13'h0505, 9'h071, 0, "R13 old beat1");
        read_col(9'h0AB, 0);
        expect_off("R13 released");
        check_burst(13'h0505, 9'h0AB, 0, 4, 0, "R13 new burst");
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_default();
        t_interleave();
        t_early();
        t_illegal();
        t_half_long();
        t_mask();
        t_freeze();
        t_deselect();
        t_restart();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule